// File: doc/BRIEF.md
# Hart Trap Entry and Return Controller

This block holds the privilege mode of one RISC-V hart and the trap state around it. That state is the interrupt-enable and previous-privilege fields of the status word, and one cause, exception-PC and trap-value register for each of the machine, supervisor and user modes. The block takes at most one control-flow event per clock: a synchronous exception, an interrupt, or a return from machine, supervisor or user mode.

For an exception, the block chooses the handling mode from two delegation masks that the CSR file supplies. The choice is never lower than the mode the hart is already running in. For an interrupt, the dispatcher has already chosen the handling mode and passes it in. Each event updates the state on the clock edge that samples it. One cycle later the block gives the pipeline a redirect pulse and gives the load-reserved logic a cancel pulse.

A separate write port lets the CSR file overwrite the status fields. An event in the same cycle takes priority over this write.

Top module: `hart_trap_unit`

## Requirements
- R1: After a synchronous reset, `priv_o` is machine mode, `stat_o` is zero, all nine cause/epc/tval outputs are zero, and neither pulse is set. Privilege codes are U=0, S=1, M=3.
- R2: For an exception with code c, the handling mode is chosen as follows. If `medeleg[c]` is set and supervisor mode exists, the handler is S. If supervisor mode exists and both `medeleg[c]` and `sedeleg[c]` are set with the N feature present, the handler is U. Without supervisor mode, `medeleg[c]` alone selects U when N is present. In every other case the handler is M.
- R3: If the chosen handling mode is below the current privilege, the trap is taken at the current privilege instead.
- R4: On a trap to M: MPIE takes MIE, MIE is cleared, and MPP takes the old privilege. `mcause_o` is {interrupt flag in the MSB, zero-extended code}. `mepc_o` takes the PC. `mtval_o` takes the trap value, or zero when `evt_tval_vld` is low.
- R5: On a trap to S: SPIE takes SIE and SIE is cleared. SPP becomes 1 when the old privilege is S and 0 when it is U. The S cause, epc and tval registers are written, and the other modes' registers are unchanged.
- R6: On a trap to U: UPIE takes UIE and UIE is cleared. The U cause, epc and tval registers are written, and the other modes' registers are unchanged.
- R7: On MRET: MIE takes MPIE, MPIE becomes 1, and the privilege takes MPP. MPP then becomes U (or M when user mode is absent). MPRV is cleared unless the new privilege is M.
- R8: On SRET: SIE takes SPIE and SPIE becomes 1. The privilege becomes S if SPP is 1 and U otherwise. SPP and MPRV are cleared.
- R9: On URET: UIE takes UPIE, UPIE becomes 1, and the privilege becomes U.
- R10: The event kinds are coded on `evt_kind` as 0 exception, 1 interrupt, 2 MRET, 3 SRET and 4 URET. Codes 5 to 7 have no effect. Each defined event gives a one-cycle pulse on `redirect_o` and `resv_cancel_o` in the cycle after it is sampled. Both outputs are low otherwise.
- R11: An interrupt is taken at `evt_int_tgt`, raised to the current privilege if it is lower. Its cause register has the MSB set.
- R12: `stat_we` loads `stat_wdata` into the status word when no event is present. An event in the same cycle takes priority, and the write is dropped. The layout of the status word is: bit0 UIE, bit1 SIE, bit2 MIE, bit3 UPIE, bit4 SPIE, bit5 MPIE, bit6 SPP, bits8:7 MPP, bit9 MPRV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 3 | Event kind code |
| evt_code | input | CODE_W | Exception or interrupt code |
| evt_int_tgt | input | 2 | Handling mode chosen for an interrupt |
| evt_pc | input | XLEN | PC of the trapping instruction |
| evt_tval_vld | input | 1 | Trap value supplied |
| evt_tval | input | XLEN | Trap value |
| medeleg | input | 2**CODE_W | Machine exception delegation mask |
| sedeleg | input | 2**CODE_W | Supervisor exception delegation mask |
| stat_we | input | 1 | Status word write strobe |
| stat_wdata | input | 10 | Status word write data |
| priv_o | output | 2 | Current privilege |
| stat_o | output | 10 | Status word |
| redirect_o | output | 1 | Fetch redirect pulse |
| resv_cancel_o | output | 1 | Load-reserved cancel pulse |
| mcause_o | output | XLEN | M cause |
| mepc_o | output | XLEN | M exception PC |
| mtval_o | output | XLEN | M trap value |
| scause_o | output | XLEN | S cause |
| sepc_o | output | XLEN | S exception PC |
| stval_o | output | XLEN | S trap value |
| ucause_o | output | XLEN | U cause |
| uepc_o | output | XLEN | U exception PC |
| utval_o | output | XLEN | U trap value |

## Verification
The delegation path is driven from a table. Each row sets a starting privilege, an exception code and a pair of masks. Together the rows separate the S choice from the U choice, show that a `sedeleg` bit alone has no effect, show that a mask bit for a different code has no effect, and show that a low handler is raised to the current mode in both S and M. A second instance built without supervisor mode shows that the mask alone can then select U.

Directed sequences push known enable values through each trap and return. These cover SPP taking both values, MRET both leaving MPRV set and clearing it, a trap with no trap value while the `evt_tval` bus carries a value, interrupts whose targets are raised, and an event that arrives together with a status write.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    EV_EXC  = 3'd0,
    EV_INT  = 3'd1,
    EV_MRET = 3'd2,
    EV_SRET = 3'd3,
    EV_URET = 3'd4
  } evkind_e;

  // Status word, MSB first; bit0 is uie.
  typedef struct packed {
    logic       mprv;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       upie;
    logic       mie;
    logic       sie;
    logic       uie;
  } stat_t;

  localparam int STAT_W    = $bits(stat_t);
  localparam int NUM_MODES = 3;  // bank index: 0 U, 1 S, 2 M

  function automatic logic [1:0] mode_idx(input logic [1:0] p);
    case (p)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/trap_deleg.sv
module trap_deleg #(
  parameter int CODE_W = 5,
  parameter int HAS_S  = 1,
  parameter int HAS_U  = 1,
  parameter int HAS_N  = 1,
  localparam int DW    = 1 << CODE_W
) (
  input  logic [2:0]        kind,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        int_tgt,
  input  logic [DW-1:0]     medeleg,
  input  logic [DW-1:0]     sedeleg,
  input  logic [1:0]        cur_priv,
  output logic [1:0]        tgt_priv
);
  import trap_pkg::*;

  localparam bit S_ON = (HAS_S != 0);
  localparam bit U_ON = (HAS_U != 0);
  localparam bit N_ON = (HAS_N != 0);

  logic       to_sup;
  logic       to_usr;
  logic [1:0] raw;

  always_comb begin
    to_sup = medeleg[code];
    if (S_ON) to_usr = to_sup & N_ON & sedeleg[code];
    else      to_usr = to_sup & N_ON;

    if (kind == EV_INT)          raw = int_tgt;
    else if (U_ON && to_usr)     raw = PRIV_U;
    else if (S_ON && to_sup)     raw = PRIV_S;
    else                         raw = PRIV_M;

    // never descend below the running privilege
    tgt_priv = (raw < cur_priv) ? cur_priv : raw;
  end

endmodule

// File: rtl/trap_status.sv
module trap_status #(
  parameter int HAS_U = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ev_ok,
  input  logic [2:0]                kind,
  input  logic [1:0]                tgt_priv,
  input  logic                      stat_we,
  input  logic [trap_pkg::STAT_W-1:0] stat_wdata,
  output logic [1:0]                priv_q,
  output trap_pkg::stat_t           stat_q
);
  import trap_pkg::*;

  localparam logic [1:0] MPP_IDLE = (HAS_U != 0) ? PRIV_U : PRIV_M;

  stat_t      stat_n;
  logic [1:0] priv_n;
  logic       is_trap;

  assign is_trap = ev_ok && (kind == EV_EXC || kind == EV_INT);

  always_comb begin
    stat_n = stat_q;
    priv_n = priv_q;
    if (ev_ok) begin
      case (kind)
        EV_EXC, EV_INT: begin
          priv_n = tgt_priv;
          case (tgt_priv)
            PRIV_M: begin
              stat_n.mpie = stat_q.mie;
              stat_n.mie  = 1'b0;
              stat_n.mpp  = priv_q;
            end
            PRIV_S: begin
              stat_n.spie = stat_q.sie;
              stat_n.sie  = 1'b0;
              stat_n.spp  = (priv_q == PRIV_S);
            end
            default: begin
              stat_n.upie = stat_q.uie;
              stat_n.uie  = 1'b0;
            end
          endcase
        end
        EV_MRET: begin
          stat_n.mie  = stat_q.mpie;
          stat_n.mpie = 1'b1;
          priv_n      = stat_q.mpp;
          stat_n.mpp  = MPP_IDLE;
          if (stat_q.mpp != PRIV_M) stat_n.mprv = 1'b0;
        end
        EV_SRET: begin
          stat_n.sie  = stat_q.spie;
          stat_n.spie = 1'b1;
          priv_n      = stat_q.spp ? PRIV_S : PRIV_U;
          stat_n.spp  = 1'b0;
          stat_n.mprv = 1'b0;
        end
        EV_URET: begin
          stat_n.uie  = stat_q.upie;
          stat_n.upie = 1'b1;
          priv_n      = PRIV_U;
        end
        default: ;
      endcase
    end else if (stat_we) begin
      stat_n = stat_t'(stat_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q <= PRIV_M;
      stat_q <= '0;
    end else begin
      priv_q <= priv_n;
      stat_q <= stat_n;
    end
  end

  // R3: a trap never lowers the privilege
  assert_never_lower_R3: assert property (@(posedge clk) disable iff (rst)
    is_trap |=> (priv_q >= $past(priv_q)));

  // R4: machine trap stacks the enable and privilege
  assert_m_stack_R4: assert property (@(posedge clk) disable iff (rst)
    (is_trap && tgt_priv == PRIV_M) |=>
      (!stat_q.mie && stat_q.mpie == $past(stat_q.mie) && stat_q.mpp == $past(priv_q)));

  // R7: MRET leaves MPIE set
  assert_mret_mpie_R7: assert property (@(posedge clk) disable iff (rst)
    (ev_ok && kind == EV_MRET) |=> stat_q.mpie);

  // R8: SRET clears SPP and MPRV
  assert_sret_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_ok && kind == EV_SRET) |=> (!stat_q.spp && !stat_q.mprv && stat_q.spie));

  // R9: URET lands in user mode
  assert_uret_user_R9: assert property (@(posedge clk) disable iff (rst)
    (ev_ok && kind == EV_URET) |=> (priv_q == PRIV_U && stat_q.upie));

endmodule

// File: rtl/trap_regbank.sv
module trap_regbank #(
  parameter int XLEN = 32,
  localparam int NM  = trap_pkg::NUM_MODES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NM-1:0]        wr_sel,
  input  logic [XLEN-1:0]      cause_in,
  input  logic [XLEN-1:0]      epc_in,
  input  logic [XLEN-1:0]      tval_in,
  output logic [NM-1:0][XLEN-1:0] cause_q,
  output logic [NM-1:0][XLEN-1:0] epc_q,
  output logic [NM-1:0][XLEN-1:0] tval_q
);

  for (genvar m = 0; m < NM; m++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst) begin
        cause_q[m] <= '0;
        epc_q[m]   <= '0;
        tval_q[m]  <= '0;
      end else if (wr_sel[m]) begin
        cause_q[m] <= cause_in;
        epc_q[m]   <= epc_in;
        tval_q[m]  <= tval_in;
      end
    end

    // R4: the selected bank captures the faulting PC
    assert_epc_capture_R4: assert property (@(posedge clk) disable iff (rst)
      wr_sel[m] |=> (epc_q[m] == $past(epc_in)));

    // R5: an unselected bank holds its value
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[m] |=> $stable(cause_q[m]));
  end

  // R6: only one bank is written per event
  assert_one_bank_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

endmodule

// File: rtl/hart_trap_unit.sv
module hart_trap_unit #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  parameter int HAS_S  = 1,
  parameter int HAS_U  = 1,
  parameter int HAS_N  = 1,
  localparam int DW    = 1 << CODE_W,
  localparam int SW    = trap_pkg::STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [2:0]        evt_kind,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [1:0]        evt_int_tgt,
  input  logic [XLEN-1:0]   evt_pc,
  input  logic              evt_tval_vld,
  input  logic [XLEN-1:0]   evt_tval,
  input  logic [DW-1:0]     medeleg,
  input  logic [DW-1:0]     sedeleg,
  input  logic              stat_we,
  input  logic [SW-1:0]     stat_wdata,
  output logic [1:0]        priv_o,
  output logic [SW-1:0]     stat_o,
  output logic              redirect_o,
  output logic              resv_cancel_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   ucause_o,
  output logic [XLEN-1:0]   uepc_o,
  output logic [XLEN-1:0]   utval_o
);
  import trap_pkg::*;

  localparam int NM    = NUM_MODES;
  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic                   ev_ok;
  logic                   is_trap;
  logic [1:0]             tgt_priv;
  logic [1:0]             priv_q;
  stat_t                  stat_q;
  logic [NM-1:0]          wr_sel;
  logic [XLEN-1:0]        cause_in;
  logic [XLEN-1:0]        tval_in;
  logic [NM-1:0][XLEN-1:0] cause_q, epc_q, tval_q;
  logic                   redir_q;
  logic                   cancel_q;

  assign ev_ok   = evt_valid && (evt_kind <= EV_URET);
  assign is_trap = ev_ok && (evt_kind == EV_EXC || evt_kind == EV_INT);

  trap_deleg #(
    .CODE_W(CODE_W), .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_N(HAS_N)
  ) u_deleg (
    .kind     (evt_kind),
    .code     (evt_code),
    .int_tgt  (evt_int_tgt),
    .medeleg  (medeleg),
    .sedeleg  (sedeleg),
    .cur_priv (priv_q),
    .tgt_priv (tgt_priv)
  );

  trap_status #(.HAS_U(HAS_U)) u_status (
    .clk        (clk),
    .rst        (rst),
    .ev_ok      (ev_ok),
    .kind       (evt_kind),
    .tgt_priv   (tgt_priv),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .priv_q     (priv_q),
    .stat_q     (stat_q)
  );

  always_comb begin
    wr_sel = '0;
    if (is_trap) wr_sel[mode_idx(tgt_priv)] = 1'b1;
  end

  assign cause_in = {(evt_kind == EV_INT), {PAD_W{1'b0}}, evt_code};
  assign tval_in  = evt_tval_vld ? evt_tval : '0;

  trap_regbank #(.XLEN(XLEN)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_sel   (wr_sel),
    .cause_in (cause_in),
    .epc_in   (evt_pc),
    .tval_in  (tval_in),
    .cause_q  (cause_q),
    .epc_q    (epc_q),
    .tval_q   (tval_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_q  <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      redir_q  <= ev_ok;
      cancel_q <= ev_ok;
    end
  end

  assign priv_o        = priv_q;
  assign stat_o        = stat_q;
  assign redirect_o    = redir_q;
  assign resv_cancel_o = cancel_q;
  assign ucause_o      = cause_q[0];
  assign uepc_o        = epc_q[0];
  assign utval_o       = tval_q[0];
  assign scause_o      = cause_q[1];
  assign sepc_o        = epc_q[1];
  assign stval_o       = tval_q[1];
  assign mcause_o      = cause_q[2];
  assign mepc_o        = epc_q[2];
  assign mtval_o       = tval_q[2];

  // R10: every defined event pulses both strobes next cycle
  assert_pulse_on_event_R10: assert property (@(posedge clk) disable iff (rst)
    ev_ok |=> (redirect_o && resv_cancel_o));

  // R10: no event, no pulse
  assert_quiet_no_event_R10: assert property (@(posedge clk) disable iff (rst)
    !ev_ok |=> (!redirect_o && !resv_cancel_o));

  // R12: a lone status write lands verbatim
  assert_stat_write_R12: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid && stat_we) |=> (stat_o == $past(stat_wdata)));

  // R11: interrupt cause carries the MSB
  assert_int_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (is_trap && evt_kind == EV_INT && tgt_priv == PRIV_M) |=> mcause_o[XLEN-1]);

endmodule

// File: tb/test_hart_trap_unit.sv
`timescale 1ns/1ps
module test_hart_trap_unit;

  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam int DW   = 1 << CW;

  localparam logic [2:0] K_EXC = 3'd0, K_INT = 3'd1, K_MRET = 3'd2,
                         K_SRET = 3'd3, K_URET = 3'd4;
  localparam logic [1:0] P_U = 2'd0, P_S = 2'd1, P_M = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            evt_valid = 0;
  logic [2:0]      evt_kind = 0;
  logic [CW-1:0]   evt_code = 0;
  logic [1:0]      evt_int_tgt = 0;
  logic [XLEN-1:0] evt_pc = 0;
  logic            evt_tval_vld = 0;
  logic [XLEN-1:0] evt_tval = 0;
  logic [DW-1:0]   medeleg = 0;
  logic [DW-1:0]   sedeleg = 0;
  logic            stat_we = 0;
  logic [9:0]      stat_wdata = 0;

  logic [1:0]  priv_o;
  logic [9:0]  stat_o;
  logic        redirect_o, resv_cancel_o;
  logic [XLEN-1:0] mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o,
                   ucause_o, uepc_o, utval_o;

  logic [1:0]  n_priv;
  logic [9:0]  n_stat;
  logic        n_redir, n_cancel;
  logic [XLEN-1:0] n_mcause, n_mepc, n_mtval, n_scause, n_sepc, n_stval,
                   n_ucause, n_uepc, n_utval;

  hart_trap_unit #(.XLEN(XLEN), .CODE_W(CW)) i_hart_trap_unit (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_code(evt_code), .evt_int_tgt(evt_int_tgt), .evt_pc(evt_pc),
    .evt_tval_vld(evt_tval_vld), .evt_tval(evt_tval), .medeleg(medeleg),
    .sedeleg(sedeleg), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .priv_o(priv_o), .stat_o(stat_o), .redirect_o(redirect_o),
    .resv_cancel_o(resv_cancel_o), .mcause_o(mcause_o), .mepc_o(mepc_o),
    .mtval_o(mtval_o), .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o),
    .ucause_o(ucause_o), .uepc_o(uepc_o), .utval_o(utval_o));

  // variant without supervisor mode, same stimulus
  hart_trap_unit #(.XLEN(XLEN), .CODE_W(CW), .HAS_S(0)) i_hart_trap_unit_nos (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_code(evt_code), .evt_int_tgt(evt_int_tgt), .evt_pc(evt_pc),
    .evt_tval_vld(evt_tval_vld), .evt_tval(evt_tval), .medeleg(medeleg),
    .sedeleg(sedeleg), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .priv_o(n_priv), .stat_o(n_stat), .redirect_o(n_redir),
    .resv_cancel_o(n_cancel), .mcause_o(n_mcause), .mepc_o(n_mepc),
    .mtval_o(n_mtval), .scause_o(n_scause), .sepc_o(n_sepc), .stval_o(n_stval),
    .ucause_o(n_ucause), .uepc_o(n_uepc), .utval_o(n_utval));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] st(input logic mprv, input logic [1:0] mpp,
      input logic spp, input logic mpie, input logic spie, input logic upie,
      input logic mie, input logic sie, input logic uie);
    return {mprv, mpp, spp, mpie, spie, upie, mie, sie, uie};
  endfunction

  task automatic do_evt(input logic [2:0] k, input logic [CW-1:0] c,
      input logic [1:0] it, input logic [XLEN-1:0] pc, input logic tv,
      input logic [XLEN-1:0] tval);
    @(negedge clk);
    evt_valid = 1; evt_kind = k; evt_code = c; evt_int_tgt = it;
    evt_pc = pc; evt_tval_vld = tv; evt_tval = tval;
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic wr_stat(input logic [9:0] v);
    @(negedge clk);
    stat_we = 1; stat_wdata = v;
    @(negedge clk);
    stat_we = 0;
  endtask

  task automatic go_priv(input logic [1:0] p);
    wr_stat(st(0, p, 0, 0, 0, 0, 0, 0, 0));
    do_evt(K_MRET, 0, 0, 0, 0, 0);
  endtask

  typedef struct packed {
    logic [1:0]    start;
    logic [CW-1:0] code;
    logic [DW-1:0] med;
    logic [DW-1:0] sed;
    logic [1:0]    exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{P_M, 5'd2, 32'h0,   32'h0,   P_M},
    '{P_U, 5'd2, 32'h0,   32'h0,   P_M},
    '{P_U, 5'd2, 32'h4,   32'h0,   P_S},
    '{P_U, 5'd2, 32'h4,   32'h4,   P_U},
    '{P_U, 5'd2, 32'h0,   32'h4,   P_M},
    '{P_S, 5'd2, 32'h4,   32'h0,   P_S},
    '{P_S, 5'd2, 32'h4,   32'h4,   P_S},
    '{P_M, 5'd2, 32'h4,   32'h4,   P_M},
    '{P_U, 5'd8, 32'h4,   32'h0,   P_M},
    '{P_U, 5'd8, 32'h100, 32'h0,   P_S}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 priv", priv_o, P_M);
    chk("R1 stat", stat_o, 0);
    chk("R1 mcause", mcause_o, 0);
    chk("R1 sepc", sepc_o, 0);
    chk("R1 utval", utval_o, 0);
    chk("R1 redirect", redirect_o, 0);

    // R2 without supervisor mode: medeleg alone picks U
    medeleg = 32'h4; sedeleg = 0;
    go_priv(P_U);
    do_evt(K_EXC, 2, 0, 32'h80, 1, 32'h5);
    chk("R2 main to S", priv_o, P_S);
    chk("R2 nos to U", n_priv, P_U);
    chk("R2 nos ucause", n_ucause, 2);

    // R2 / R3 table walk
    for (int i = 0; i < 10; i++) begin
      logic [XLEN-1:0] pc;
      pc = 32'h100 + i * 4;
      medeleg = VECS[i].med; sedeleg = VECS[i].sed;
      go_priv(VECS[i].start);
      do_evt(K_EXC, VECS[i].code, 0, pc, 1, i);
      chk("R2 R3 target", priv_o, VECS[i].exp);
      case (VECS[i].exp)
        P_U: begin chk("R6 uepc", uepc_o, pc); chk("R6 ucause", ucause_o, VECS[i].code); end
        P_S: begin chk("R5 sepc", sepc_o, pc); chk("R5 scause", scause_o, VECS[i].code); end
        default: begin chk("R4 mepc", mepc_o, pc); chk("R4 mcause", mcause_o, VECS[i].code); end
      endcase
    end

    // R4 machine trap from U
    medeleg = 0; sedeleg = 0;
    go_priv(P_U);
    wr_stat(st(0, P_U, 0, 0, 0, 0, 1, 0, 0));
    do_evt(K_EXC, 2, 0, 32'h1000, 1, 32'hABC);
    chk("R4 priv", priv_o, P_M);
    chk("R4 stat", stat_o, st(0, P_U, 0, 1, 0, 0, 0, 0, 0));
    chk("R4 mcause", mcause_o, 2);
    chk("R4 mepc", mepc_o, 32'h1000);
    chk("R4 mtval", mtval_o, 32'hABC);
    chk("R10 redirect", redirect_o, 1);
    chk("R10 cancel", resv_cancel_o, 1);
    @(negedge clk);
    chk("R10 redirect drops", redirect_o, 0);
    chk("R10 cancel drops", resv_cancel_o, 0);

    // R4 no trap value given
    do_evt(K_EXC, 3, 0, 32'h2000, 0, 32'h55);
    chk("R4 mtval zero", mtval_o, 0);
    chk("R4 mpp from M", stat_o, st(0, P_M, 0, 0, 0, 0, 0, 0, 0));

    // R5 supervisor trap from S
    medeleg = 32'h4;
    go_priv(P_S);
    wr_stat(st(0, P_U, 0, 0, 0, 0, 0, 1, 0));
    do_evt(K_EXC, 2, 0, 32'h3000, 1, 32'h77);
    chk("R5 priv", priv_o, P_S);
    chk("R5 stat", stat_o, st(0, P_U, 1, 0, 1, 0, 0, 0, 0));
    chk("R5 sepc", sepc_o, 32'h3000);
    chk("R5 stval", stval_o, 32'h77);
    chk("R5 mepc kept", mepc_o, 32'h2000);

    // R8 SRET back to S, clears MPRV
    wr_stat(st(1, P_U, 1, 0, 1, 0, 0, 0, 0));
    do_evt(K_SRET, 0, 0, 0, 0, 0);
    chk("R8 priv S", priv_o, P_S);
    chk("R8 stat", stat_o, st(0, P_U, 0, 0, 1, 0, 0, 1, 0));

    // R8 SRET with SPP clear goes to U
    wr_stat(st(0, P_U, 0, 0, 0, 0, 0, 0, 0));
    do_evt(K_SRET, 0, 0, 0, 0, 0);
    chk("R8 priv U", priv_o, P_U);
    chk("R8 stat U", stat_o, st(0, P_U, 0, 0, 1, 0, 0, 0, 0));

    // R6 user trap
    medeleg = 32'h100; sedeleg = 32'h100;
    wr_stat(st(0, P_U, 0, 0, 0, 0, 0, 0, 1));
    do_evt(K_EXC, 8, 0, 32'h4000, 1, 32'h99);
    chk("R6 priv", priv_o, P_U);
    chk("R6 stat", stat_o, st(0, P_U, 0, 0, 0, 1, 0, 0, 0));
    chk("R6 ucause", ucause_o, 8);
    chk("R6 uepc", uepc_o, 32'h4000);
    chk("R6 scause kept", scause_o, 2);

    // R9 URET
    do_evt(K_URET, 0, 0, 0, 0, 0);
    chk("R9 priv", priv_o, P_U);
    chk("R9 stat", stat_o, st(0, P_U, 0, 0, 0, 1, 0, 0, 1));

    // R11 interrupt to S from U
    medeleg = 0; sedeleg = 0;
    do_evt(K_INT, 5, P_S, 32'h5000, 0, 32'h1);
    chk("R11 priv", priv_o, P_S);
    chk("R11 scause", scause_o, 32'h8000_0005);
    chk("R11 stval", stval_o, 0);
    chk("R11 stat", stat_o, st(0, P_U, 0, 0, 0, 1, 0, 0, 1));

    // R11 interrupt aimed at U while in S is raised to S
    do_evt(K_INT, 1, P_U, 32'h5100, 0, 0);
    chk("R11 clamp priv", priv_o, P_S);
    chk("R11 clamp scause", scause_o, 32'h8000_0001);
    chk("R11 clamp spp", stat_o[6], 1);

    // R7 MRET to S clears MPRV
    do_evt(K_EXC, 2, 0, 32'h6000, 0, 0);
    chk("R4 back to M", priv_o, P_M);
    wr_stat(st(1, P_S, 0, 1, 0, 0, 0, 0, 0));
    do_evt(K_MRET, 0, 0, 0, 0, 0);
    chk("R7 priv S", priv_o, P_S);
    chk("R7 stat", stat_o, st(0, P_U, 0, 1, 0, 0, 1, 0, 0));

    // R7 MRET to M keeps MPRV
    do_evt(K_EXC, 2, 0, 32'h6100, 0, 0);
    wr_stat(st(1, P_M, 0, 0, 0, 0, 0, 0, 0));
    do_evt(K_MRET, 0, 0, 0, 0, 0);
    chk("R7 priv M", priv_o, P_M);
    chk("R7 mprv kept", stat_o, st(1, P_U, 0, 1, 0, 0, 0, 0, 0));

    // R12 event beats a same-cycle status write
    @(negedge clk);
    evt_valid = 1; evt_kind = K_URET; stat_we = 1; stat_wdata = 10'h3FF;
    @(negedge clk);
    evt_valid = 0; stat_we = 0;
    chk("R12 event wins", stat_o, st(1, P_U, 0, 1, 0, 1, 0, 0, 0));
    chk("R9 uret from M", priv_o, P_U);

    // R12 plain write, no pulse
    wr_stat(10'h155);
    chk("R12 write", stat_o, 10'h155);
    chk("R12 no redirect", redirect_o, 0);

    // R10 undefined kind changes nothing
    do_evt(3'd6, 2, 0, 32'h7000, 1, 1);
    chk("R10 undefined no pulse", redirect_o, 0);
    chk("R10 undefined stat", stat_o, 10'h155);
    chk("R10 undefined priv", priv_o, P_U);

    // R1 reset again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 re-reset priv", priv_o, P_M);
    chk("R1 re-reset stat", stat_o, 0);
    chk("R1 re-reset scause", scause_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule